// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block watches a two-wire serial bus and decides whether the local slave is being addressed. It takes the raw clock and data lines, brings them into the system clock domain, detects START and STOP conditions, and shifts in the address byte or bytes that follow each START. It compares them with a programmed own address. A mode input selects 7-bit or 10-bit addressing.

In 7-bit mode a single byte carries the address and the direction bit. In 10-bit mode the first byte must carry the fixed prefix, the two upper address bits and the write direction. That yields a partial match. The second byte must then equal the lower eight address bits, which yields the full match. Every accepted byte raises a one-cycle match pulse. A separate byte engine uses these outputs to drive acknowledge, move data and stretch the clock.

The matcher also sorts each first byte into one of four address classes: ordinary, general call, reserved, or 10-bit prefix. Firmware or the byte engine can use this class to handle special addresses.

Top module: `slave_addr_detect`

## Requirements
- R1: After reset, `addressed`, `matchPulse`, `readDir` and `fullMatch` are 0 and `addrClass` is 0.
- R2: In 7-bit mode (`tenBitMode`=0), bus bits are sampled on rising SCL, first bit MSB. A first byte whose upper seven bits equal `ownAddr[6:0]` gives exactly one `matchPulse` and sets `addressed`. Later bytes in the same transfer give no further pulse.
- R3: In 7-bit mode, bit 0 of a matching first byte is copied to `readDir` (1 = read).
- R4: In 7-bit mode, a first byte whose upper seven bits differ from `ownAddr[6:0]` gives no pulse and leaves `addressed` at 0.
- R5: After each START, `addrClass` holds the class of the first byte's upper seven bits (the code). Code 0x00 gives 1 (general call). Codes 0x01-0x03 and 0x7C-0x7F give 2 (reserved). Codes 0x78-0x7B give 3 (10-bit prefix). Any other code gives 0.
- R6: In 10-bit mode, a first byte equal to {5'b11110, `ownAddr[9:8]`, 0} gives one pulse with `fullMatch` at 0 and `addressed` at 0. A following byte equal to `ownAddr[7:0]` then gives a second pulse, sets `fullMatch` and sets `addressed`.
- R7: In 10-bit mode, a first byte with bit 0 set, or with a wrong prefix or wrong upper bits, gives no pulse. The block then ignores the rest of the transfer.
- R8: In 10-bit mode, a second byte different from `ownAddr[7:0]` gives no pulse and leaves `fullMatch` and `addressed` at 0.
- R9: A STOP clears `addressed`.
- R10: A repeated START at any point abandons the current comparison. The next byte is treated as a new first byte.
- R11: While `enable` is 0, START conditions are ignored, so no pulse is produced and `addressed` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows address detection |
| tenBitMode | input | 1 | 1 selects 10-bit addressing |
| ownAddr | input | 10 | Own slave address |
| sclIn | input | 1 | Raw bus clock line |
| sdaIn | input | 1 | Raw bus data line |
| matchPulse | output | 1 | One-cycle pulse per accepted address byte |
| addressed | output | 1 | Slave fully addressed until STOP or START |
| readDir | output | 1 | Direction bit of the 7-bit match |
| fullMatch | output | 1 | Complete 10-bit match (0 after a partial one) |
| addrClass | output | 2 | Class of the first byte after START |

## Verification
An SCL rising edge on the pin becomes visible to the shifter three clocks later: two synchronizer stages plus one edge register. The byte-complete strobe follows one clock after that. The match outputs, the class and the pulse follow one clock after the strobe, so all results are due four to five clocks after the eighth rising SCL edge of a byte. The bench holds each bus phase for eight clocks and samples each result at the end of the acknowledge phase that follows a byte, well past that point. A monitor on the falling clock edge counts match pulses, and every scenario compares that count before and after. This catches pulses that are missing, extra or late.

// File: rtl/sad_pkg.sv
package sad_pkg;

  localparam int BYTE_W = 8;
  localparam logic [4:0] PREFIX10 = 5'b11110;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FIRST,
    ST_SECOND,
    ST_HELD
  } sadState_t;

  typedef enum logic [1:0] {
    CLS_NORMAL   = 2'd0,
    CLS_GENCALL  = 2'd1,
    CLS_RESERVED = 2'd2,
    CLS_PREFIX10 = 2'd3
  } addrClass_t;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;
    logic latchClass;
  } sadCtrl_t;

endpackage

// File: rtl/sad_sync.sv
module sad_sync #(
  parameter int STAGES = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= RESET_VAL;
        else       pipe <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= {STAGES{RESET_VAL}};
        else       pipe <= {pipe[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/sad_datapath.sv
module sad_datapath
  import sad_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  sadCtrl_t          ctrl,
  output logic              startDet,
  output logic              stopDet,
  output logic              byteDone,
  output logic              hit7,
  output logic              hitPrefix,
  output logic              hitLow,
  output logic              rwBit,
  output logic [1:0]        addrClass
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(BYTE_W);

  logic sclS, sdaS, sclD, sdaD;
  logic sclRise;
  logic [BYTE_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;
  logic [6:0]        code;
  addrClass_t        classNext;
  logic [1:0]        classReg;

  sad_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sclSync (
    .clk(clk), .rstN(rstN), .din(sclIn), .dout(sclS));
  sad_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sdaSync (
    .clk(clk), .rstN(rstN), .din(sdaIn), .dout(sdaS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  assign sclRise  = sclS & ~sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;

  // bit counter: eight data slots then one acknowledge slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (ctrl.restart) begin
        bitCnt <= '0;
      end else if (sclRise) begin
        if (bitCnt == ACK_SLOT) begin
          bitCnt <= '0;
        end else begin
          shiftReg <= {shiftReg[BYTE_W-2:0], sdaS};
          bitCnt   <= bitCnt + 1'b1;
          byteDone <= (bitCnt == LAST_DATA);
        end
      end
    end
  end

  // comparators
  assign code      = shiftReg[7:1];
  assign rwBit     = shiftReg[0];
  assign hit7      = (code == ownAddr[6:0]);
  assign hitPrefix = (shiftReg[7:3] == PREFIX10) && (shiftReg[2:1] == ownAddr[9:8]);
  assign hitLow    = (shiftReg == ownAddr[7:0]);

  always_comb begin
    if (code == 7'h00)                        classNext = CLS_GENCALL;
    else if (code <= 7'h03 || code >= 7'h7C)  classNext = CLS_RESERVED;
    else if (code >= 7'h78)                   classNext = CLS_PREFIX10;
    else                                      classNext = CLS_NORMAL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                classReg <= CLS_NORMAL;
    else if (ctrl.restart)    classReg <= CLS_NORMAL;
    else if (ctrl.latchClass) classReg <= classNext;
  end

  assign addrClass = classReg;
endmodule

// File: rtl/sad_control.sv
module sad_control
  import sad_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  logic     tenBitMode,
  input  logic     startDet,
  input  logic     stopDet,
  input  logic     byteDone,
  input  logic     hit7,
  input  logic     hitPrefix,
  input  logic     hitLow,
  input  logic     rwBit,
  output sadCtrl_t ctrl,
  output logic     matchPulse,
  output logic     addressed,
  output logic     readDir,
  output logic     fullMatch
);
  sadState_t state;

  always_comb begin
    ctrl.restart    = startDet & enable;
    ctrl.latchClass = enable & byteDone & (state == ST_FIRST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      matchPulse <= 1'b0;
      readDir    <= 1'b0;
      fullMatch  <= 1'b0;
    end else begin
      matchPulse <= 1'b0;
      if (!enable) begin
        state     <= ST_IDLE;
        fullMatch <= 1'b0;
      end else if (startDet) begin
        state     <= ST_FIRST;
        readDir   <= 1'b0;
        fullMatch <= 1'b0;
      end else if (stopDet) begin
        state <= ST_IDLE;
      end else if (byteDone) begin
        unique case (state)
          ST_FIRST: begin
            if (!tenBitMode) begin
              if (hit7) begin
                matchPulse <= 1'b1;
                readDir    <= rwBit;
                state      <= ST_HELD;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              fullMatch <= 1'b0;
              if (hitPrefix && !rwBit) begin
                matchPulse <= 1'b1;
                state      <= ST_SECOND;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_SECOND: begin
            if (hitLow) begin
              matchPulse <= 1'b1;
              fullMatch  <= 1'b1;
              state      <= ST_HELD;
            end else begin
              fullMatch <= 1'b0;
              state     <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign addressed = (state == ST_HELD);
endmodule

// File: rtl/slave_addr_detect.sv
module slave_addr_detect
  import sad_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              tenBitMode,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              matchPulse,
  output logic              addressed,
  output logic              readDir,
  output logic              fullMatch,
  output logic [1:0]        addrClass
);
  sadCtrl_t ctrl;
  logic startDet, stopDet, byteDone;
  logic hit7, hitPrefix, hitLow, rwBit;

  sad_datapath #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ownAddr(ownAddr),
    .ctrl(ctrl), .startDet(startDet), .stopDet(stopDet), .byteDone(byteDone),
    .hit7(hit7), .hitPrefix(hitPrefix), .hitLow(hitLow), .rwBit(rwBit),
    .addrClass(addrClass));

  sad_control u_ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .tenBitMode(tenBitMode),
    .startDet(startDet), .stopDet(stopDet), .byteDone(byteDone),
    .hit7(hit7), .hitPrefix(hitPrefix), .hitLow(hitLow), .rwBit(rwBit),
    .ctrl(ctrl), .matchPulse(matchPulse), .addressed(addressed),
    .readDir(readDir), .fullMatch(fullMatch));
endmodule

// File: rtl/sad_checker.sv
module sad_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic tenBitMode,
  input logic startSeen,
  input logic stopSeen,
  input logic matchPulse,
  input logic addressed,
  input logic readDir,
  input logic fullMatch
);
  // R2
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |=> !matchPulse);

  // R11
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!addressed && !matchPulse));

  // R6
  full_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fullMatch) |-> (matchPulse && addressed));

  // R3
  read_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (matchPulse && readDir) |-> !$past(tenBitMode));

  // R9
  stop_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopSeen && !startSeen && enable) |=> !addressed);
endmodule

bind slave_addr_detect sad_checker u_sadChk (
  .clk(clk), .rstN(rstN), .enable(enable), .tenBitMode(tenBitMode),
  .startSeen(startDet), .stopSeen(stopDet), .matchPulse(matchPulse),
  .addressed(addressed), .readDir(readDir), .fullMatch(fullMatch));

// File: tb/slave_addr_detect_bench.sv
module slave_addr_detect_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PHASE      = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b1;
  logic tenBitMode = 1'b0;
  logic [9:0] ownAddr = 10'h05A;
  logic sclLine = 1'b1;
  logic sdaLine = 1'b1;
  logic matchPulse, addressed, readDir, fullMatch;
  logic [1:0] addrClass;

  int nChecks = 0;
  int nFails  = 0;
  int pulseCnt = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slave_addr_detect u_slave_addr_detect (
    .clk(clk), .rstN(rstN), .enable(enable), .tenBitMode(tenBitMode),
    .ownAddr(ownAddr), .sclIn(sclLine), .sdaIn(sdaLine),
    .matchPulse(matchPulse), .addressed(addressed), .readDir(readDir),
    .fullMatch(fullMatch), .addrClass(addrClass));

  always @(negedge clk) if (matchPulse) pulseCnt++;

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic phase();
    repeat (PHASE) @(negedge clk);
  endtask

  task automatic busStart();
    sdaLine = 1'b1; phase();
    sclLine = 1'b1; phase();
    sdaLine = 1'b0; phase();
    sclLine = 1'b0; phase();
  endtask

  task automatic busStop();
    sdaLine = 1'b0; phase();
    sclLine = 1'b1; phase();
    sdaLine = 1'b1; phase();
  endtask

  task automatic busByte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdaLine = b[i]; phase();
      sclLine = 1'b1; phase();
      sclLine = 1'b0;
    end
    sdaLine = 1'b1; phase();
    sclLine = 1'b1; phase();
    sclLine = 1'b0; phase();
  endtask

  task automatic t_reset();
    chk("R1 addressed", addressed, 0);
    chk("R1 matchPulse", matchPulse, 0);
    chk("R1 readDir", readDir, 0);
    chk("R1 fullMatch", fullMatch, 0);
    chk("R1 addrClass", addrClass, 0);
  endtask

  task automatic t_sevenWrite();
    int base = pulseCnt;
    tenBitMode = 1'b0; ownAddr = 10'h05A;
    busStart(); busByte(8'hB4);
    chk("R2 addressed", addressed, 1);
    chk("R2 pulses", pulseCnt - base, 1);
    chk("R3 readDir write", readDir, 0);
    chk("R5 ordinary class", addrClass, 0);
    busByte(8'hB4);
    chk("R2 no pulse on data", pulseCnt - base, 1);
    busStop();
    chk("R9 stop clears", addressed, 0);
  endtask

  task automatic t_sevenRead();
    int base = pulseCnt;
    busStart(); busByte(8'hB5);
    chk("R3 readDir read", readDir, 1);
    chk("R3 pulses", pulseCnt - base, 1);
    busStop();
  endtask

  task automatic t_sevenMiss();
    int base = pulseCnt;
    busStart(); busByte(8'hB6);
    chk("R4 addressed", addressed, 0);
    chk("R4 pulses", pulseCnt - base, 0);
    busStop();
  endtask

  task automatic classOne(input logic [7:0] b, input int exp);
    busStart(); busByte(b);
    chk("R5 class", addrClass, exp);
    busStop();
  endtask

  task automatic t_classes();
    int base = pulseCnt;
    classOne(8'h00, 1);
    classOne(8'h04, 2);
    classOne(8'h07, 2);
    classOne(8'h08, 0);
    classOne(8'hF8, 2);
    classOne(8'hFE, 2);
    classOne(8'hF0, 3);
    classOne(8'hF7, 3);
    chk("R4 no pulse for foreign codes", pulseCnt - base, 0);
  endtask

  task automatic t_tenFull();
    int base = pulseCnt;
    tenBitMode = 1'b1; ownAddr = 10'h2A5;
    busStart(); busByte(8'hF4);
    chk("R6 partial pulse", pulseCnt - base, 1);
    chk("R6 partial fullMatch", fullMatch, 0);
    chk("R6 partial addressed", addressed, 0);
    chk("R5 prefix class", addrClass, 3);
    busByte(8'hA5);
    chk("R6 full pulses", pulseCnt - base, 2);
    chk("R6 fullMatch", fullMatch, 1);
    chk("R6 addressed", addressed, 1);
    busStop();
    chk("R9 stop clears 10-bit", addressed, 0);
  endtask

  task automatic t_tenReadFirst();
    int base = pulseCnt;
    busStart(); busByte(8'hF5); busByte(8'hA5);
    chk("R7 read first pulses", pulseCnt - base, 0);
    chk("R7 read first fullMatch", fullMatch, 0);
    busStop();
  endtask

  task automatic t_tenBadPrefix();
    int base = pulseCnt;
    busStart(); busByte(8'hF0); busByte(8'hA5);
    chk("R7 upper bits pulses", pulseCnt - base, 0);
    chk("R7 upper bits addressed", addressed, 0);
    busStop();
    busStart(); busByte(8'hE4); busByte(8'hA5);
    chk("R7 prefix pulses", pulseCnt - base, 0);
    busStop();
  endtask

  task automatic t_tenLowMiss();
    int base = pulseCnt;
    busStart(); busByte(8'hF4); busByte(8'hA4);
    chk("R8 pulses", pulseCnt - base, 1);
    chk("R8 fullMatch", fullMatch, 0);
    chk("R8 addressed", addressed, 0);
    busStop();
  endtask

  task automatic t_restart();
    int base = pulseCnt;
    busStart(); busByte(8'hF4);
    busStart(); busByte(8'hA5);
    chk("R10 aborted pulses", pulseCnt - base, 1);
    chk("R10 aborted fullMatch", fullMatch, 0);
    busStart(); busByte(8'hF4); busByte(8'hA5);
    chk("R10 restarted pulses", pulseCnt - base, 3);
    chk("R10 restarted fullMatch", fullMatch, 1);
    busStop();
  endtask

  task automatic t_disabled();
    int base = pulseCnt;
    tenBitMode = 1'b0; ownAddr = 10'h05A;
    enable = 1'b0;
    busStart(); busByte(8'hB4);
    chk("R11 addressed", addressed, 0);
    chk("R11 pulses", pulseCnt - base, 0);
    busStop();
    enable = 1'b1;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    t_sevenWrite();
    t_sevenRead();
    t_sevenMiss();
    t_classes();
    t_tenFull();
    t_tenReadFirst();
    t_tenBadPrefix();
    t_tenLowMiss();
    t_restart();
    t_disabled();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule